// File: doc/BRIEF.md
# Radio module power-enable sequencer

This block sits in the host and owns the enable line of an attached wireless module. It watches a battery-good flag, an IO-supply-good flag and the free-running 32.768 kHz slow clock, and it raises enable only after both supplies are good, the slow clock has been measured as present and in frequency, and a settle time has passed. While enable is high it keeps checking those three conditions. If one of them drops, enable falls on the next cycle and a sticky fault flag is set.

A shutdown always lowers enable first. The supply-off permit rises only after a release delay that starts when enable falls, so the host removes the supplies in the correct order. Between two enables a minimum off gap applies. A separate permit tells the host when it may drive signals toward the module, and a ready flag marks the end of the module's internal start-up time. All times are set in microseconds and converted to system-clock cycles from a clock-frequency parameter. The supply flags and the slow clock pass through two-flop synchronizers. The on and off requests are single-cycle pulses that are synchronous to the system clock.

Top module: `radio_en_seq`

## Requirements
- R1: After reset, enable, ready, fault and the drive permit are 0, and the supply-off permit is 1.
- R2: Enable rises only while both supply flags are high and the slow clock is judged good. It rises at least SETTLE_US after the last of these conditions became true, and the supplies may become good in either order.
- R3: The slow clock is judged good only after GOOD_WINDOWS consecutive measurement windows of WIN_US. In each window the rising-edge count must lie within TOL_EDGES of the nominal 32.768 kHz count. A clock at the wrong frequency keeps enable low.
- R4: An off request while enable is high lowers enable on the next cycle. The supply-off permit is 0 while enable is high and rises RELEASE_US after enable falls. It falls again on the cycle after an accepted on request.
- R5: Enable never rises less than GAP_US after it last fell.
- R6: The drive permit is 1 exactly when both supply flags are high, three cycles after the inputs change.
- R7: Ready rises PWR_US plus RDY_US after enable rises and falls together with enable.
- R8: If a supply flag drops while enable is high, enable falls within three cycles and fault is set. Fault stays set with no further stimulus.
- R9: If the slow clock stops while enable is high, enable falls within about four nominal slow-clock periods and fault is set.
- R10: Fault is cleared by reset, or on the cycle after an accepted on request.
- R11: An on request is ignored during the release delay. An off request given in the same cycle as an on request takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bat_good_i | input | 1 | Battery supply good (asynchronous) |
| io_good_i | input | 1 | IO supply good (asynchronous) |
| slow_clk_i | input | 1 | Raw 32.768 kHz slow clock |
| on_req_i | input | 1 | Power-on request pulse |
| off_req_i | input | 1 | Power-off request pulse |
| enable_o | output | 1 | Module enable |
| io_drive_o | output | 1 | Host may drive signals toward the module |
| supply_off_ok_o | output | 1 | Supplies may be removed |
| ready_o | output | 1 | Module start-up time has elapsed |
| fault_o | output | 1 | Sticky loss-of-precondition flag |

## Verification
A supply-flag change reaches the drive permit three cycles later, and enable three cycles plus the settle count later. An off request moves enable after one cycle. Ready follows the enable rise by exactly the start-up count, and the supply-off permit follows the enable fall by the release count. The bench stamps every stimulus with a cycle number and pushes the expected output edge, with a window of a few cycles, into a scoreboard. A monitor samples on the falling clock edge and matches every output change against that queue. Any change it does not expect, or any expected edge that misses its window, counts as a miscompare. The slow-clock stall result is not pinned to one cycle, because the stall counter starts at the last slow-clock edge, so it is checked against a window bounded by the stall limit.

// File: rtl/radio_en_seq.sv
module radio_en_seq #(
  parameter int CLK_KHZ      = 100000,
  parameter int SETTLE_US    = 10,
  parameter int GAP_US       = 60,
  parameter int RELEASE_US   = 10,
  parameter int PWR_US       = 5000,
  parameter int RDY_US       = 4500,
  parameter int WIN_US       = 1000,
  parameter int TOL_EDGES    = 3,
  parameter int GOOD_WINDOWS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bat_good_i,
  input  logic io_good_i,
  input  logic slow_clk_i,
  input  logic on_req_i,
  input  logic off_req_i,
  output logic enable_o,
  output logic io_drive_o,
  output logic supply_off_ok_o,
  output logic ready_o,
  output logic fault_o
);

  localparam int SETTLE_RAW  = CLK_KHZ * SETTLE_US / 1000;
  localparam int GAP_RAW     = CLK_KHZ * GAP_US / 1000;
  localparam int RELEASE_RAW = CLK_KHZ * RELEASE_US / 1000;
  localparam int STARTUP_RAW = CLK_KHZ * (PWR_US + RDY_US) / 1000;
  localparam int WIN_RAW     = CLK_KHZ * WIN_US / 1000;
  localparam int SETTLE_CYC  = SETTLE_RAW  < 1 ? 1 : SETTLE_RAW;
  localparam int GAP_CYC     = GAP_RAW     < 1 ? 1 : GAP_RAW;
  localparam int RELEASE_CYC = RELEASE_RAW < 1 ? 1 : RELEASE_RAW;
  localparam int STARTUP_CYC = STARTUP_RAW < 1 ? 1 : STARTUP_RAW;
  localparam int WIN_CYC     = WIN_RAW     < 2 ? 2 : WIN_RAW;
  localparam int EXP_EDGES   = 32768 * WIN_US / 1000000;
  localparam int EDGE_LO     = EXP_EDGES > TOL_EDGES ? EXP_EDGES - TOL_EDGES : 0;
  localparam int EDGE_HI     = EXP_EDGES + TOL_EDGES;
  localparam int STALL_CYC   = (4 * CLK_KHZ * 1000) / 32768;
  localparam int CW = $clog2(STARTUP_CYC + SETTLE_CYC + RELEASE_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int EW = $clog2(WIN_CYC + 2);
  localparam int SW = $clog2(STALL_CYC + 1);
  localparam int NW = $clog2(GOOD_WINDOWS + 1);

  typedef enum logic [6:0] {
    S_OFF    = 7'b0000001,
    S_WAIT   = 7'b0000010,
    S_SETTLE = 7'b0000100,
    S_START  = 7'b0001000,
    S_READY  = 7'b0010000,
    S_HOLD   = 7'b0100000,
    S_REL    = 7'b1000000
  } state_t;

  logic [1:0] bat_q, io_q;
  logic [2:0] sk_q;
  logic bat_s, io_s, sk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bat_q <= '0;
      io_q  <= '0;
      sk_q  <= '0;
    end else begin
      bat_q <= {bat_q[0], bat_good_i};
      io_q  <= {io_q[0], io_good_i};
      sk_q  <= {sk_q[1:0], slow_clk_i};
    end
  end

  assign bat_s   = bat_q[1];
  assign io_s    = io_q[1];
  assign sk_rise = sk_q[1] & ~sk_q[2];

  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt, edges_now;
  logic [SW-1:0] idle_cnt;
  logic [NW-1:0] good_run;
  logic win_end, in_tol, stall, clk_ok;

  assign edges_now = edge_cnt + EW'(sk_rise);
  assign win_end   = (win_cnt == WW'(WIN_CYC - 1));
  assign in_tol    = (int'(edges_now) >= EDGE_LO) && (int'(edges_now) <= EDGE_HI);
  assign stall     = (idle_cnt >= SW'(STALL_CYC));
  assign clk_ok    = (good_run == NW'(GOOD_WINDOWS)) && !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      idle_cnt <= '0;
      good_run <= '0;
    end else begin
      if (sk_rise)     idle_cnt <= '0;
      else if (!stall) idle_cnt <= idle_cnt + 1'b1;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        edge_cnt <= edges_now;
      end
      if (stall)
        good_run <= '0;
      else if (win_end) begin
        if (!in_tol)                              good_run <= '0;
        else if (good_run != NW'(GOOD_WINDOWS))   good_run <= good_run + 1'b1;
      end
    end
  end

  logic pre_ok;
  assign pre_ok = bat_s & io_s & clk_ok;

  state_t state, nxt;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap_cnt;
  logic cnt_clr, drop, fault_set, fault_clr, fault_q, io_drive_q;

  always_comb begin
    nxt       = state;
    cnt_clr   = 1'b0;
    drop      = 1'b0;
    fault_set = 1'b0;
    fault_clr = 1'b0;
    unique case (state)
      S_OFF, S_REL:
        if (on_req_i && !off_req_i) begin
          nxt       = S_WAIT;
          fault_clr = 1'b1;
        end
      S_WAIT:
        if (off_req_i) nxt = S_OFF;
        else if (pre_ok && gap_cnt == '0) begin
          nxt     = S_SETTLE;
          cnt_clr = 1'b1;
        end
      S_SETTLE:
        if (off_req_i) nxt = S_OFF;
        else if (!pre_ok) nxt = S_WAIT;
        else if (cnt == CW'(SETTLE_CYC - 1)) begin
          nxt     = S_START;
          cnt_clr = 1'b1;
        end
      S_START, S_READY:
        if (!pre_ok || off_req_i) begin
          nxt       = S_HOLD;
          cnt_clr   = 1'b1;
          drop      = 1'b1;
          fault_set = !pre_ok;
        end else if (state == S_START && cnt == CW'(STARTUP_CYC - 1))
          nxt = S_READY;
      S_HOLD:
        if (cnt == CW'(RELEASE_CYC - 1)) nxt = S_REL;
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_OFF;
      cnt        <= '0;
      gap_cnt    <= '0;
      fault_q    <= 1'b0;
      io_drive_q <= 1'b0;
    end else begin
      state <= nxt;
      if (cnt_clr) cnt <= '0;
      else if (state == S_SETTLE || state == S_START || state == S_HOLD) cnt <= cnt + 1'b1;
      if (drop) gap_cnt <= GW'(GAP_CYC);
      else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
      if (fault_set) fault_q <= 1'b1;
      else if (fault_clr) fault_q <= 1'b0;
      io_drive_q <= bat_s & io_s;
    end
  end

  assign enable_o        = (state == S_START) || (state == S_READY);
  assign ready_o         = (state == S_READY);
  assign supply_off_ok_o = (state == S_OFF) || (state == S_REL);
  assign fault_o         = fault_q;
  assign io_drive_o      = io_drive_q;

  a_r2_en_needs_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_o) |-> $past(pre_ok));
  a_r8_loss_drops_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && !pre_ok) |=> (!enable_o && fault_o));
  a_r4_no_release_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enable_o) |-> !supply_off_ok_o);
  a_r5_gap_elapsed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_o) |-> ($past(gap_cnt) == '0));
  a_r7_ready_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(enable_o));
  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !on_req_i) |=> fault_o);
  a_r3_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state));

endmodule

// File: tb/tb_radio_en_seq.sv
module tb_radio_en_seq;
  localparam int PRE = 10, REL = 10, GAP = 60, ST = 350, STALL = 122;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bat = 1'b0, vio = 1'b0, sk = 1'b0, on_r = 1'b0, off_r = 1'b0;
  logic en, io_dr, rel, rdy, flt;
  int cyc = 0, checks = 0, fails = 0, sk_mode = 0, sk_cnt = 0;
  bit mon_on = 1'b0, done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  radio_en_seq #(.CLK_KHZ(1000), .PWR_US(200), .RDY_US(150), .WIN_US(500),
                 .GOOD_WINDOWS(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bat_good_i(bat), .io_good_i(vio),
    .slow_clk_i(sk), .on_req_i(on_r), .off_req_i(off_r), .enable_o(en),
    .io_drive_o(io_dr), .supply_off_ok_o(rel), .ready_o(rdy), .fault_o(flt));

  always @(negedge clk) begin
    if (sk_mode != 0) begin
      sk_cnt <= sk_cnt + 1;
      if (sk_cnt >= ((sk_mode == 1) ? 14 : 4)) begin
        sk <= ~sk;
        sk_cnt <= 0;
      end
    end
  end

  typedef struct { int sig; bit val; int lo; int hi; string tag; } exp_t;
  exp_t exq[$];
  logic [4:0] prev;
  string nm [5] = '{"enable", "ready", "supply_off_ok", "io_drive", "fault"};
  string rq [5] = '{"R2", "R7", "R4", "R6", "R8"};

  task automatic expect_ev(int sig, bit val, int lo, int hi, string tag);
    exp_t e;
    e.sig = sig; e.val = val; e.lo = cyc + lo; e.hi = cyc + hi; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      logic [4:0] cur;
      cur = {flt, io_dr, rel, rdy, en};
      for (int s = 0; s < 5; s++) begin
        if (cur[s] != prev[s]) begin
          int idx;
          idx = -1;
          for (int i = 0; i < exq.size(); i++)
            if (idx < 0 && exq[i].sig == s) idx = i;
          checks++;
          if (idx < 0) begin
            fails++;
            $display("FAIL %s: unexpected %s change actual %0d expected %0d at cycle %0d",
                     rq[s], nm[s], cur[s], prev[s], cyc);
          end else begin
            if (exq[idx].val != cur[s] || cyc < exq[idx].lo || cyc > exq[idx].hi) begin
              fails++;
              $display("FAIL %s: %s actual %0d at cycle %0d expected %0d in [%0d,%0d]",
                       exq[idx].tag, nm[s], cur[s], cyc, exq[idx].val, exq[idx].lo, exq[idx].hi);
            end
            exq.delete(idx);
          end
        end
      end
      for (int i = exq.size() - 1; i >= 0; i--)
        if (cyc > exq[i].hi) begin
          checks++;
          fails++;
          $display("FAIL %s: %s actual none expected %0d by cycle %0d",
                   exq[i].tag, nm[exq[i].sig], exq[i].val, exq[i].hi);
          exq.delete(i);
        end
      prev = cur;
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_on();
    on_r = 1'b1; @(negedge clk); on_r = 1'b0;
  endtask

  task automatic pulse_off();
    off_r = 1'b1; @(negedge clk); off_r = 1'b0;
  endtask

  task automatic wait_ready_after_en();
    while (!en) @(negedge clk);
    expect_ev(1, 1'b1, ST - 2, ST + 2, "R7");
    waitc(ST + 10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    waitc(4);
    check(en == 0 && rdy == 0 && flt == 0 && io_dr == 0, "R1 outputs low", {en, rdy, flt, io_dr}, 0);
    check(rel == 1, "R1 supply_off_ok", rel, 1);
    rst_n = 1'b1;
    waitc(2);
    prev = {flt, io_dr, rel, rdy, en};
    mon_on = 1'b1;
    sk_mode = 1;
    waitc(2000);

    // R2: on request, IO supply first, battery last
    expect_ev(2, 1'b0, 1, 2, "R4");
    pulse_on();
    vio = 1'b1;
    waitc(60);
    check(en == 0, "R2 one supply only", en, 0);
    check(io_dr == 0, "R6 one supply only", io_dr, 0);
    expect_ev(3, 1'b1, 2, 4, "R6");
    expect_ev(0, 1'b1, PRE, PRE + 4, "R2");
    expect_ev(1, 1'b1, PRE + ST, PRE + ST + 6, "R7");
    bat = 1'b1;
    waitc(PRE + ST + 20);
    check(rdy == 1 && en == 1, "R7 ready held", {rdy, en}, 3);

    // R4 off, then R5 minimum gap
    expect_ev(0, 1'b0, 1, 2, "R4");
    expect_ev(1, 1'b0, 1, 2, "R7");
    expect_ev(2, 1'b1, REL, REL + 4, "R4");
    pulse_off();
    waitc(REL + 4);
    expect_ev(2, 1'b0, 1, 2, "R4");
    expect_ev(0, 1'b1, GAP - REL - 5, GAP + PRE - REL, "R5");
    pulse_on();
    wait_ready_after_en();

    // R8 supply loss while on
    expect_ev(0, 1'b0, 2, 4, "R8");
    expect_ev(1, 1'b0, 2, 4, "R8");
    expect_ev(3, 1'b0, 2, 4, "R6");
    expect_ev(4, 1'b1, 2, 4, "R8");
    expect_ev(2, 1'b1, REL + 2, REL + 6, "R4");
    bat = 1'b0;
    waitc(120);
    check(flt == 1, "R8 fault sticky", flt, 1);
    expect_ev(3, 1'b1, 2, 4, "R6");
    bat = 1'b1;
    waitc(10);
    check(flt == 1, "R8 fault sticky after restore", flt, 1);
    // R10 on request clears fault
    expect_ev(4, 1'b0, 1, 2, "R10");
    expect_ev(2, 1'b0, 1, 2, "R4");
    expect_ev(0, 1'b1, PRE, PRE + 5, "R2");
    pulse_on();
    wait_ready_after_en();

    // R9 slow clock stall while on
    expect_ev(0, 1'b0, 1, STALL + 40, "R9");
    expect_ev(1, 1'b0, 1, STALL + 40, "R9");
    expect_ev(4, 1'b1, 1, STALL + 40, "R9");
    expect_ev(2, 1'b1, REL, STALL + 50 + REL, "R4");
    sk_mode = 0;
    waitc(300);
    check(flt == 1 && en == 0, "R9 stall fault", {flt, en}, 2);

    // R3 wrong frequency keeps enable low
    sk_mode = 2;
    expect_ev(4, 1'b0, 1, 2, "R10");
    expect_ev(2, 1'b0, 1, 2, "R4");
    pulse_on();
    waitc(3000);
    check(en == 0, "R3 fast slow clock", en, 0);
    expect_ev(0, 1'b1, PRE, 2000, "R3");
    sk_mode = 1;
    wait_ready_after_en();

    // R11 on request during release delay is ignored
    expect_ev(0, 1'b0, 1, 2, "R4");
    expect_ev(1, 1'b0, 1, 2, "R7");
    expect_ev(2, 1'b1, REL, REL + 4, "R4");
    pulse_off();
    waitc(2);
    pulse_on();
    waitc(150);
    check(en == 0 && rel == 1, "R11 on ignored in release delay", {en, rel}, 1);
    on_r = 1'b1; off_r = 1'b1;
    @(negedge clk);
    on_r = 1'b0; off_r = 1'b0;
    waitc(10);
    check(rel == 1 && en == 0, "R11 off priority", {en, rel}, 1);

    // R2 other order: battery first, IO last
    expect_ev(3, 1'b0, 2, 4, "R6");
    vio = 1'b0; bat = 1'b0;
    waitc(10);
    expect_ev(2, 1'b0, 1, 2, "R4");
    pulse_on();
    bat = 1'b1;
    waitc(40);
    check(en == 0 && io_dr == 0, "R2 battery only", {en, io_dr}, 0);
    expect_ev(3, 1'b1, 2, 4, "R6");
    expect_ev(0, 1'b1, PRE, PRE + 4, "R2");
    vio = 1'b1;
    wait_ready_after_en();

    // R8 IO loss, then R10 reset clears fault
    expect_ev(0, 1'b0, 2, 4, "R8");
    expect_ev(1, 1'b0, 2, 4, "R8");
    expect_ev(3, 1'b0, 2, 4, "R6");
    expect_ev(4, 1'b1, 2, 4, "R8");
    expect_ev(2, 1'b1, REL + 2, REL + 6, "R4");
    vio = 1'b0;
    waitc(50);
    check(flt == 1, "R8 IO loss fault", flt, 1);
    check(exq.size() == 0, "R4 scoreboard drained", exq.size(), 0);
    mon_on = 1'b0;
    rst_n = 1'b0;
    waitc(3);
    check(flt == 0 && en == 0 && rel == 1, "R10 reset clears fault", {flt, en, rel}, 1);
    finish_run();
  end
endmodule